// File: doc/BRIEF.md
# Grayscale Cycle Blanking Sequencer

This block paces a daisy chain of 16-channel, 12-bit grayscale PWM LED drivers. It divides the system clock down to a gated grayscale clock and counts a fixed number of grayscale periods per PWM cycle. When the count is reached, it parks the grayscale clock low and waits a guard time. It then raises the blanking line. If a new data frame has been shifted into the chain since the previous blanking interval, it pulses the latch line while blanking is high. Finally it drops blanking and restarts the grayscale clock.

A companion serializer shifts the frame. This block tells it when to start through a clear-to-send flag. In the normal mode the flag opens when a cycle starts and closes two thirds of the way through the cycle, or earlier when the serializer strobes that its shift is finished. In the alternate mode the shift happens while blanking is held. The flag is raised inside the blanking interval, the sequencer waits for the serializer's strobe, pulses the latch, and only then releases blanking. Blanking therefore lasts longer by the shift time.

An enable input gates everything. Pulling it low stops the grayscale clock and blanks the outputs without waiting for the cycle to finish. Raising it again always passes through a complete blanking interval before any output is driven.

Top module: `gs_blank_seq`

## Requirements
- R1: While reset is active and right after it is released with enable low, the blank output is 1 and the latch, grayscale-clock and clear-to-send outputs are 0.
- R2: Between a falling edge of blank and the next rising edge, the grayscale clock rises exactly GS_STEPS times. Its period is 2*HALF_DIV system clocks, and its first rising edge comes HALF_DIV clocks after blank falls.
- R3: The grayscale clock is 0 whenever blank is 1. Before each rising edge of blank, the grayscale clock has been 0 for exactly GUARD_CLKS system clocks (the blank-low window is 2*HALF_DIV*GS_STEPS + GUARD_CLKS clocks).
- R4: In the normal mode (mode select 0, sampled when blanking begins), blank stays high for exactly BLANK_LEN system clocks.
- R5: The latch output pulses only in a blanking interval that began after a send-done strobe, one strobe giving one pulse. The pulse starts one clock after blank rises, lasts XLAT_LEN clocks, and ends while blank is still 1. The next interval without a new strobe has no pulse.
- R6: In the normal mode, clear-to-send rises together with the fall of blank and falls after (2*GS_STEPS)/3 grayscale periods, that is after 2*HALF_DIV*((2*GS_STEPS)/3) clocks, unless a strobe closes it earlier.
- R7: A send-done strobe forces clear-to-send to 0 on the next clock, and it stays 0 until the next cycle opens it.
- R8: When enable is sampled low, the grayscale clock is 0 from the next clock and blank is 1 within GUARD_CLKS+1 clocks. Both then hold, with clear-to-send and latch at 0, for as long as enable stays low.
- R9: When enable returns high, blank stays 1 for a full BLANK_LEN-clock blanking interval, with a latch pulse if a strobe arrived while disabled, and then falls.
- R10: In the alternate mode (mode select 1), clear-to-send is 1 while blank is held high and blank stays high until the send-done strobe. The latch pulse follows, blank falls BLANK_LEN clocks after the strobe, and clear-to-send stays 0 during the following grayscale cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable; low blanks all driver outputs |
| done_i | input | 1 | One-clock strobe from the serializer: frame shift finished |
| shift_in_blank_i | input | 1 | Mode select: 0 shift during the cycle, 1 shift inside blanking |
| gsclk_o | output | 1 | Gated grayscale clock to the driver chain |
| blank_o | output | 1 | Blanking line, 1 turns all driver outputs off |
| xlat_o | output | 1 | Latch pulse moving shifted data into the grayscale registers |
| cts_o | output | 1 | Clear-to-send flag for the serializer |

## Verification
The bench builds the block with GS_STEPS=12, HALF_DIV=2, GUARD_CLKS=2, BLANK_LEN=6 and XLAT_LEN=2. A full cycle then takes about 56 system clocks and the send window closes after 8 grayscale periods. This puts many complete cycles within reach, so the window close, the guard gap, the latch position and the pending-latch clear can each be measured edge by edge. The short cycle also lets one run cover a disable in the middle of a cycle, a strobe taken while disabled, and an alternate-mode interval that is held open for several clocks before its strobe arrives.

// File: rtl/gs_blank_pkg.sv
package gs_blank_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RUN   = 3'd1,
        ST_GUARD = 3'd2,
        ST_BLANK = 3'd3,
        ST_SHIFT = 3'd4
    } seq_state_e;

endpackage

// File: rtl/gs_step_timer.sv
// Grayscale clock divider and period counter. Runs only while run_i is 1;
// otherwise everything is cleared and the clock output rests low.
module gs_step_timer #(
    parameter int GS_STEPS  = 4096,
    parameter int HALF_DIV  = 4,
    parameter int WIN_STEPS = 2730
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic gsclk_o,
    output logic cycle_end_o,
    output logic win_end_o
);

    localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int STEP_W = (GS_STEPS > 1) ? $clog2(GS_STEPS) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(GS_STEPS - 1);
    localparam logic [STEP_W-1:0] WIN_LAST  = STEP_W'(WIN_STEPS - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [STEP_W-1:0] step;
        logic              gclk;
    } tmr_t;

    tmr_t r_d, r_q;
    logic fall_edge;

    // Decoded from registered state only, so the caller may use these to
    // decide run_i without forming a loop.
    assign fall_edge   = r_q.gclk && (r_q.div == DIV_LAST);
    assign cycle_end_o = fall_edge && (r_q.step == STEP_LAST);
    assign win_end_o   = fall_edge && (r_q.step == WIN_LAST);
    assign gsclk_o     = r_q.gclk;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d = '0;
        end else if (r_q.div == DIV_LAST) begin
            r_d.div  = '0;
            r_d.gclk = ~r_q.gclk;
            if (r_q.gclk) begin
                r_d.step = r_q.step + 1'b1;
            end
        end else begin
            r_d.div = r_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/gs_latch_flag.sv
// Remembers that a frame shift completed and has not yet been latched.
module gs_latch_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic take_i,
    output logic pending_o
);

    logic pend_d, pend_q;

    // A strobe in the same clock as a take is consumed by that take.
    always_comb begin
        if (take_i) begin
            pend_d = 1'b0;
        end else begin
            pend_d = pend_q | done_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending_o = pend_q;

endmodule

// File: rtl/gs_blank_seq.sv
module gs_blank_seq #(
    parameter int GS_STEPS   = 4096,
    parameter int HALF_DIV   = 4,
    parameter int GUARD_CLKS = 1,
    parameter int BLANK_LEN  = 8,
    parameter int XLAT_LEN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic done_i,
    input  logic shift_in_blank_i,
    output logic gsclk_o,
    output logic blank_o,
    output logic xlat_o,
    output logic cts_o
);
    import gs_blank_pkg::*;

    // The window closes two thirds of the way through the cycle.
    localparam int WIN_STEPS = (GS_STEPS * 2) / 3;
    localparam int PH_MAX    = (BLANK_LEN > GUARD_CLKS) ? BLANK_LEN : GUARD_CLKS;
    localparam int PH_W      = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] GUARD_LAST = PH_W'(GUARD_CLKS - 1);
    localparam logic [PH_W-1:0] BLANK_LAST = PH_W'(BLANK_LEN - 1);
    localparam logic [PH_W-1:0] XL_FIRST   = PH_W'(1);
    localparam logic [PH_W-1:0] XL_LAST    = PH_W'(XLAT_LEN);

    typedef struct packed {
        seq_state_e      state;
        logic [PH_W-1:0] cnt;
        logic            go;
        logic            shift_mode;
        logic            blank;
        logic            xlat;
        logic            cts;
    } seq_t;

    seq_t s_d, s_q;
    logic take;
    logic open_blank;
    logic pending;
    logic tmr_run;
    logic cycle_end;
    logic win_end;

    // The timer counts only while the sequencer stays in the run state, so
    // any exit parks the grayscale clock low on that same edge.
    assign tmr_run = (s_q.state == ST_RUN) && (s_d.state == ST_RUN);

    gs_step_timer #(
        .GS_STEPS  (GS_STEPS),
        .HALF_DIV  (HALF_DIV),
        .WIN_STEPS (WIN_STEPS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (tmr_run),
        .gsclk_o     (gsclk_o),
        .cycle_end_o (cycle_end),
        .win_end_o   (win_end)
    );

    gs_latch_flag u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_i),
        .take_i    (take),
        .pending_o (pending)
    );

    always_comb begin
        s_d        = s_q;
        take       = 1'b0;
        open_blank = 1'b0;

        case (s_q.state)
            ST_OFF: begin
                s_d.blank = 1'b1;
                s_d.cts   = 1'b0;
                if (en_i) begin
                    open_blank = 1'b1;
                end
            end
            ST_RUN: begin
                if (win_end) begin
                    s_d.cts = 1'b0;
                end
                if (!en_i || cycle_end) begin
                    s_d.state = ST_GUARD;
                    s_d.cnt   = '0;
                end
            end
            ST_GUARD: begin
                if (s_q.cnt == GUARD_LAST) begin
                    if (en_i) begin
                        open_blank = 1'b1;
                    end else begin
                        s_d.state = ST_OFF;
                        s_d.blank = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!en_i) begin
                    s_d.state = ST_OFF;
                end else if (done_i) begin
                    s_d.state = ST_BLANK;
                    s_d.cnt   = '0;
                    s_d.go    = 1'b1;
                    take      = 1'b1;
                end
            end
            ST_BLANK: begin
                if (s_q.cnt == BLANK_LAST) begin
                    if (en_i) begin
                        s_d.state = ST_RUN;
                        s_d.blank = 1'b0;
                        s_d.cts   = ~s_q.shift_mode;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.state = ST_OFF;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.state = ST_OFF;
                s_d.blank = 1'b1;
            end
        endcase

        // Start of a blanking interval: the mode is sampled here.
        if (open_blank) begin
            s_d.blank      = 1'b1;
            s_d.shift_mode = shift_in_blank_i;
            s_d.cnt        = '0;
            if (shift_in_blank_i) begin
                s_d.state = ST_SHIFT;
                s_d.cts   = 1'b1;
                s_d.go    = 1'b0;
            end else begin
                s_d.state = ST_BLANK;
                s_d.go    = pending | done_i;
                take      = 1'b1;
            end
        end

        // A finished shift or a disable closes the window at once.
        if (done_i || !en_i) begin
            s_d.cts = 1'b0;
        end

        s_d.xlat = (s_d.state == ST_BLANK) && s_d.go &&
                   (s_d.cnt >= XL_FIRST) && (s_d.cnt <= XL_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.state      <= ST_OFF;
            s_q.blank      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign blank_o = s_q.blank;
    assign xlat_o  = s_q.xlat;
    assign cts_o   = s_q.cts;

endmodule

// File: rtl/gs_blank_seq_chk.sv
module gs_blank_seq_chk #(
    parameter int XLAT_LEN = 2
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic done_i,
    input logic gsclk_o,
    input logic blank_o,
    input logic xlat_o,
    input logic cts_o
);

    assert_gsclk_quiet_in_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> !gsclk_o);

    assert_guard_before_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_o) |-> $past(!gsclk_o));

    assert_latch_inside_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_o |-> blank_o);

    assert_latch_ends_blanked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xlat_o) |-> blank_o);

    generate
        if (XLAT_LEN >= 2) begin : g_width
            assert_latch_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(xlat_o) |=> xlat_o);
        end
    endgenerate

    assert_done_closes_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !cts_o);

    assert_disable_stops_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !gsclk_o);

    assert_disable_closes_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !cts_o);

endmodule

bind gs_blank_seq gs_blank_seq_chk #(.XLAT_LEN(XLAT_LEN)) u_gs_blank_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .done_i  (done_i),
    .gsclk_o (gsclk_o),
    .blank_o (blank_o),
    .xlat_o  (xlat_o),
    .cts_o   (cts_o)
);

// File: tb/gs_blank_seq_bench.sv
module gs_blank_seq_bench;

    localparam int GS    = 12;
    localparam int HALF  = 2;
    localparam int GUARD = 2;
    localparam int BLEN  = 6;
    localparam int XLEN  = 2;

    localparam int LOW_LEN = 2 * HALF * GS + GUARD;
    localparam int WIN_LEN = 2 * HALF * ((2 * GS) / 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic done = 1'b0;
    logic mode = 1'b0;
    logic gsclk, blank, xlat, cts;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gs_blank_seq #(
        .GS_STEPS   (GS),
        .HALF_DIV   (HALF),
        .GUARD_CLKS (GUARD),
        .BLANK_LEN  (BLEN),
        .XLAT_LEN   (XLEN)
    ) u_gs_blank_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .en_i             (en),
        .done_i           (done),
        .shift_in_blank_i (mode),
        .gsclk_o          (gsclk),
        .blank_o          (blank),
        .xlat_o           (xlat),
        .cts_o            (cts)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Starts on a blank-low sample, returns on the first blank-high sample.
    task automatic measure_low(output int n_low, output int n_rise, output int first_rise,
                               output int n_cts, output int trail);
        logic prev;
        prev = 1'b0;
        n_low = 0; n_rise = 0; first_rise = -1; n_cts = 0; trail = 0;
        while (blank == 1'b0 && n_low < 5000) begin
            if (gsclk && !prev) begin
                n_rise++;
                if (first_rise < 0) first_rise = n_low;
            end
            if (cts) n_cts++;
            if (gsclk) trail = 0; else trail++;
            prev = gsclk;
            n_low++;
            step();
        end
    endtask

    // Starts on a blank-high sample, returns on the first blank-low sample.
    task automatic measure_high(output int n_high, output int n_xlat, output int x_first,
                                output int gs_seen);
        n_high = 0; n_xlat = 0; x_first = -1; gs_seen = 0;
        while (blank == 1'b1 && n_high < 5000) begin
            if (xlat) begin
                n_xlat++;
                if (x_first < 0) x_first = n_high;
            end
            if (gsclk) gs_seen++;
            n_high++;
            step();
        end
    endtask

    task automatic t_reset();
        chk("R1", "blank in reset", int'(blank), 1);
        chk("R1", "xlat in reset", int'(xlat), 0);
        chk("R1", "gsclk in reset", int'(gsclk), 0);
        chk("R1", "cts in reset", int'(cts), 0);
        rst_n = 1'b1;
        repeat (4) step();
        chk("R1", "blank after reset, disabled", int'(blank), 1);
        chk("R1", "cts after reset, disabled", int'(cts), 0);
        chk("R1", "xlat after reset, disabled", int'(xlat), 0);
    endtask

    task automatic t_first_cycle();
        int nh, nx, xf, gs, nl, nr, fr, nc, tr;
        en = 1'b1;
        step();
        measure_high(nh, nx, xf, gs);
        chk("R9", "blank length after enable", nh, BLEN);
        chk("R5", "no latch without data", nx, 0);
        chk("R6", "cts at cycle start", int'(cts), 1);
        measure_low(nl, nr, fr, nc, tr);
        chk("R2", "gsclk rising edges per cycle", nr, GS);
        chk("R2", "first gsclk rise offset", fr, HALF);
        chk("R3", "blank-low window length", nl, LOW_LEN);
        chk("R3", "gsclk low before blank", tr, GUARD);
        chk("R6", "cts window length", nc, WIN_LEN);
    endtask

    task automatic t_steady_blank();
        int nh, nx, xf, gs;
        measure_high(nh, nx, xf, gs);
        chk("R4", "normal blank length", nh, BLEN);
        chk("R3", "gsclk during blank", gs, 0);
        chk("R5", "no latch without new data", nx, 0);
    endtask

    task automatic t_done_latch();
        int nh, nx, xf, gs, nl, nr, fr, nc, tr, open_cnt;
        repeat (5) step();
        chk("R6", "cts open mid-window", int'(cts), 1);
        done = 1'b1;
        step();
        done = 1'b0;
        chk("R7", "cts after done strobe", int'(cts), 0);
        open_cnt = 0;
        while (blank == 1'b0 && open_cnt < 5000) begin
            if (cts) open_cnt++;
            step();
        end
        chk("R7", "cts stays closed after shift", open_cnt, 0);
        measure_high(nh, nx, xf, gs);
        chk("R5", "latch pulse width", nx, XLEN);
        chk("R5", "latch pulse start", xf, 1);
        chk("R4", "blank length with latch", nh, BLEN);
        measure_low(nl, nr, fr, nc, tr);
        chk("R6", "window reopens next cycle", nc, WIN_LEN);
        measure_high(nh, nx, xf, gs);
        chk("R5", "pending cleared after latch", nx, 0);
    endtask

    task automatic t_disable();
        int k, bad;
        repeat (10) step();
        en = 1'b0;
        step();
        chk("R8", "gsclk stopped after disable", int'(gsclk), 0);
        k = 1;
        while (blank == 1'b0 && k < 50) begin
            step();
            k++;
        end
        chk("R8", "samples until blank", k, GUARD + 1);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (!blank || gsclk || cts || xlat) bad++;
            if (i == 5) done = 1'b1;
            step();
            done = 1'b0;
        end
        chk("R8", "outputs off while disabled", bad, 0);
    endtask

    task automatic t_reenable();
        int nh, nx, xf, gs;
        en = 1'b1;
        step();
        measure_high(nh, nx, xf, gs);
        chk("R9", "blank length on re-enable", nh, BLEN);
        chk("R9", "latch of data sent while off", nx, XLEN);
        chk("R5", "latch start on re-enable", xf, 1);
    endtask

    task automatic t_shift_mode();
        int nh, nx, xf, gs, nl, nr, fr, nc, tr, bad, k;
        mode = 1'b1;
        k = 0;
        while (blank == 1'b0 && k < 5000) begin
            step();
            k++;
        end
        chk("R10", "cts raised inside blanking", int'(cts), 1);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (!blank || !cts || xlat || gsclk) bad++;
        end
        chk("R10", "blank held waiting for shift", bad, 0);
        done = 1'b1;
        step();
        done = 1'b0;
        chk("R10", "cts closed by done in blanking", int'(cts), 0);
        measure_high(nh, nx, xf, gs);
        chk("R10", "blank length after done", nh, BLEN);
        chk("R10", "latch width after done", nx, XLEN);
        chk("R10", "latch start after done", xf, 1);
        mode = 1'b0;
        measure_low(nl, nr, fr, nc, tr);
        chk("R10", "no cts during run", nc, 0);
        chk("R2", "edges per cycle, shift mode", nr, GS);
        measure_high(nh, nx, xf, gs);
        chk("R4", "back to normal blank length", nh, BLEN);
        chk("R5", "no latch after mode return", nx, 0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_first_cycle();
        t_steady_blank();
        t_done_latch();
        t_disable();
        t_reenable();
        t_shift_mode();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule